// File: doc/BRIEF.md
# Streaming Integral Image Generator

This block turns a raster-ordered stream of 8-bit grayscale pixels into the matching stream of integral-image values. Each output is the sum of every pixel in the rectangle that runs from the frame origin to the current pixel, both corners included. It accepts one pixel per clock and returns the matching sum exactly two cycles later.

Inside, a per-line accumulator keeps the running total of the current scan line. A line memory holds, for each column, the integral value produced one line earlier. For each pixel the line total and the stored value from the line above are added to give the output. That result is then written back into the same column slot, where the next line will read it. The frame size comes from two configuration inputs, and a start-of-frame flag aligns the stream.

Each output also carries a width tag. The tag is the number of bits that any sum at that position can need. It is found from the row and column through a shared log2 table and is never smaller than the true requirement.

Top module: `integral_image_gen`

## Requirements
- R1: After reset `out_valid` is low. The first accepted pixel is taken as row 0, column 0 even when `in_sof` is not raised.
- R2: For the pixel at row i, column j, `out_sum` equals the sum of all pixels at rows 0..i and columns 0..j of the current frame.
- R3: Every accepted pixel produces exactly one output, with `out_valid` high on the second rising edge after the edge that accepted it. Outputs come in input order.
- R4: A pixel accepted with `in_sof` high becomes row 0, column 0 at any point in a frame. Rows 0 of the new frame take no contribution from stored values.
- R5: Each line has `cfg_cols` pixels and each frame has `cfg_rows` lines. After the last pixel of a frame, the next pixel becomes row 0, column 0 without `in_sof`.
- R6: `out_bits` equals 8 + ceil(log2(i+1)) + ceil(log2(j+1)). Examples: 8 at (0,0), 18 at row 1023 column 0, and 19 at row 1 column 1023.
- R7: `out_sum` is always below 2 to the power `out_bits`.
- R8: Cycles with `in_valid` low produce no output and leave the position, the line accumulator and the stored line unchanged.
- R9: Any width and height from 1 to 1024 is handled, including a one-column frame where the same memory slot is read and written on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_cols | input | 11 | Pixels per line, 1 to 1024 |
| cfg_rows | input | 11 | Lines per frame, 1 to 1024 |
| in_valid | input | 1 | Pixel present this cycle |
| in_sof | input | 1 | This pixel starts a new frame |
| in_pix | input | 8 | Grayscale pixel value |
| out_valid | output | 1 | Output sum present |
| out_sum | output | 28 | Integral value for the position |
| out_bits | output | 5 | Bits needed to hold a sum at that position |

## Verification
The sums are tested with several kinds of frame, each chosen to show up a different fault.

- A ramp frame exposes swapped or misaligned rows and columns.
- An all-255 frame drives every sum to the largest value its position allows, so it tests both the adder width and the tag bound.
- A pseudo-random 256-wide frame exercises realistic data flow through the line memory.

Further frames target boundaries and timing:

- A single-column frame 1024 lines tall isolates same-slot read-after-write forwarding and reaches the largest row tag.
- A 1024-wide frame reaches the largest column tag.
- Back-to-back frames without a start flag check automatic wrap.
- An aborted frame followed by a start flag checks restart.
- Idle gaps between pixels check that stalls leave the results unchanged.

// File: rtl/integral_image_gen.sv
module integral_image_gen #(
  parameter int PIX_W  = 8,
  parameter int IDX_W  = 10,
  parameter int SUM_W  = 28,
  parameter int BITS_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W:0]    cfg_cols,
  input  logic [IDX_W:0]    cfg_rows,
  input  logic              in_valid,
  input  logic              in_sof,
  input  logic [PIX_W-1:0]  in_pix,
  output logic              out_valid,
  output logic [SUM_W-1:0]  out_sum,
  output logic [BITS_W-1:0] out_bits
);
  localparam int DEPTH = 1 << IDX_W;

  function automatic logic [BITS_W-1:0] bit_len(input logic [IDX_W-1:0] n);
    logic [BITS_W-1:0] r;
    r = '0;
    for (int b = 0; b < IDX_W; b++)
      if (n[b]) r = BITS_W'(b + 1);
    return r;
  endfunction

  logic [BITS_W-1:0] lg_rom [DEPTH];
  for (genvar k = 0; k < DEPTH; k++) begin : g_lg
    assign lg_rom[k] = bit_len(IDX_W'(k));
  end

  logic [IDX_W-1:0] row_q, col_q;
  logic [SUM_W-1:0] acc_q;

  wire [IDX_W-1:0] pos_row  = in_sof ? '0 : row_q;
  wire [IDX_W-1:0] pos_col  = in_sof ? '0 : col_q;
  wire [SUM_W-1:0] line_sum = (in_sof ? '0 : acc_q) + SUM_W'(in_pix);
  wire             last_col = ({1'b0, pos_col} == cfg_cols - 1'b1);
  wire             last_row = ({1'b0, pos_row} == cfg_rows - 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      row_q <= '0;
      col_q <= '0;
      acc_q <= '0;
    end else if (in_valid) begin
      col_q <= last_col ? '0 : pos_col + 1'b1;
      acc_q <= last_col ? '0 : line_sum;
      row_q <= last_col ? (last_row ? '0 : pos_row + 1'b1) : pos_row;
    end
  end

  logic             s1_valid, s1_top;
  logic [IDX_W-1:0] s1_row, s1_col;
  logic [SUM_W-1:0] s1_line, s1_prev;
  logic [SUM_W-1:0] line_mem [DEPTH];

  wire [SUM_W-1:0] result = s1_line + (s1_top ? '0 : s1_prev);
  wire             fwd    = s1_valid && (s1_col == pos_col);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_top   <= 1'b0;
      s1_row   <= '0;
      s1_col   <= '0;
      s1_line  <= '0;
      s1_prev  <= '0;
    end else begin
      s1_valid <= in_valid;
      if (in_valid) begin
        s1_row  <= pos_row;
        s1_col  <= pos_col;
        s1_top  <= (pos_row == '0);
        s1_line <= line_sum;
        s1_prev <= fwd ? result : line_mem[pos_col];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (s1_valid) line_mem[s1_col] <= result;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_sum   <= '0;
      out_bits  <= '0;
    end else begin
      out_valid <= s1_valid;
      if (s1_valid) begin
        out_sum  <= result;
        out_bits <= BITS_W'(PIX_W) + lg_rom[s1_row] + lg_rom[s1_col];
      end
    end
  end

  logic [1:0] age_q;
  always_ff @(posedge clk) begin
    if (!rst_n) age_q <= '0;
    else if (age_q != 2'd2) age_q <= age_q + 1'b1;
  end

  assert_latency_R3: assert property (@(posedge clk) disable iff (!rst_n || age_q != 2'd2)
    out_valid == $past(in_valid, 2));

  assert_tag_covers_sum_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((out_sum >> out_bits) == '0));

  assert_tag_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_bits >= BITS_W'(PIX_W) && out_bits <= BITS_W'(PIX_W + 2*IDX_W)));

  assert_stall_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(row_q) && $stable(col_q) && $stable(acc_q)));

  assert_sof_origin_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_sof) |=> ##1 (out_valid && out_sum == SUM_W'($past(in_pix, 2))));
endmodule

// File: tb/test_integral_image_gen.sv
module test_integral_image_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [10:0] cfg_cols = 11'd8, cfg_rows = 11'd4;
  logic        in_valid = 1'b0, in_sof = 1'b0;
  logic [7:0]  in_pix = '0;
  logic        out_valid;
  logic [27:0] out_sum;
  logic [4:0]  out_bits;

  integral_image_gen i_integral_image_gen (
    .clk, .rst_n, .cfg_cols, .cfg_rows, .in_valid, .in_sof, .in_pix,
    .out_valid, .out_sum, .out_bits);

  always #2 clk = ~clk;

  int tests = 0, fails = 0;
  longint cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  longint prev_row [1024];
  longint cur_row  [1024];
  int mrow = 0, mcol = 0, ncols = 8, nrows = 4;
  longint q_sum[$];
  int     q_bits[$];
  longint q_stamp[$];
  string  tag = "R1";
  logic [15:0] lfsr = 16'hACE1;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s [%s] actual=%0d expected=%0d", req, tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (q_sum.size() == 0) begin
        check(1'b0, "R3 unexpected output", 1, 0);
      end else begin
        longint es, st; int eb;
        es = q_sum.pop_front(); eb = q_bits.pop_front(); st = q_stamp.pop_front();
        check(out_sum == es, "R2 sum", out_sum, es);
        check(out_bits == eb, "R6 width tag", out_bits, eb);
        check((longint'(out_sum) >> out_bits) == 0, "R7 tag covers sum", out_sum, eb);
        check(cyc == st + 2, "R3 latency", cyc - st, 2);
      end
    end
  end

  task automatic put(input logic [7:0] p, input bit sof);
    longint up, left, ul, v;
    if (sof) begin mrow = 0; mcol = 0; end
    up   = (mrow == 0) ? 0 : prev_row[mcol];
    left = (mcol == 0) ? 0 : cur_row[mcol-1];
    ul   = (mrow == 0 || mcol == 0) ? 0 : prev_row[mcol-1];
    v = longint'(p) + up + left - ul;
    cur_row[mcol] = v;
    q_sum.push_back(v);
    q_bits.push_back(8 + $clog2(mrow + 1) + $clog2(mcol + 1));
    q_stamp.push_back(cyc);
    if (mcol == ncols - 1) begin
      for (int c = 0; c < ncols; c++) prev_row[c] = cur_row[c];
      mcol = 0;
      mrow = (mrow == nrows - 1) ? 0 : mrow + 1;
    end else mcol++;
    in_valid = 1'b1; in_sof = sof; in_pix = p;
    @(negedge clk);
    in_valid = 1'b0; in_sof = 1'b0;
  endtask

  function automatic logic [7:0] pattern(input int kind, input int r, input int c);
    case (kind)
      0: return 8'hFF;
      1: return 8'((r * 7 + c * 3) & 255);
      default: begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        return lfsr[7:0];
      end
    endcase
  endfunction

  task automatic drain();
    repeat (4) @(negedge clk);
    check(q_sum.size() == 0, "R3 all outputs returned", q_sum.size(), 0);
  endtask

  task automatic frame(input int cols, input int rows, input int kind, input bit sof,
                       input int npix, input int gap);
    cfg_cols = 11'(cols); cfg_rows = 11'(rows);
    ncols = cols; nrows = rows;
    for (int k = 0; k < npix; k++) begin
      put(pattern(kind, k / cols, k % cols), sof && k == 0);
      repeat (gap) @(negedge clk);
    end
  endtask

  // R1: idle after reset, first pixel taken as origin without a start flag
  task automatic test_reset();
    tag = "R1 reset";
    for (int k = 0; k < 3; k++) check(out_valid == 1'b0, "R1 idle after reset", out_valid, 0);
    frame(8, 4, 1, 1'b0, 32, 0);
    drain();
  endtask

  // R2 R7: saturated frame
  task automatic test_full_scale();
    tag = "R7 all 255";
    frame(5, 3, 0, 1'b1, 15, 0);
    drain();
  endtask

  // R2: random data through a 256-wide line
  task automatic test_random_wide();
    tag = "R2 random 256";
    frame(256, 4, 2, 1'b1, 1024, 0);
    drain();
  endtask

  // R4: abort a frame midway and restart with the start flag
  task automatic test_restart();
    tag = "R4 restart";
    frame(6, 4, 2, 1'b1, 10, 0);
    frame(6, 4, 1, 1'b1, 24, 0);
    drain();
  endtask

  // R5: second frame follows with no start flag
  task automatic test_wrap();
    tag = "R5 wrap";
    frame(4, 3, 1, 1'b1, 12, 0);
    frame(4, 3, 2, 1'b0, 12, 0);
    drain();
  endtask

  // R8: idle gaps between pixels, no output during them
  task automatic test_stall();
    tag = "R8 stall";
    frame(6, 4, 2, 1'b1, 24, 2);
    drain();
  endtask

  // R9 R6: one column, 1024 lines, back-to-back same-slot reuse; tag 18 at row 1023
  task automatic test_narrow();
    tag = "R9 one column";
    frame(1, 1024, 2, 1'b1, 1024, 0);
    drain();
  endtask

  // R6 R9: 1024 columns; tag 19 at row 1 column 1023
  task automatic test_wide();
    tag = "R6 1024 wide";
    frame(1024, 2, 0, 1'b1, 2048, 0);
    drain();
  endtask

  initial begin
    fork
      begin
        repeat (200000) @(posedge clk);
        tag = "watchdog";
        check(1'b0, "R3 watchdog", 0, 1);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
      end
    join_none
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    test_full_scale();
    test_random_wide();
    test_restart();
    test_wrap();
    test_stall();
    test_narrow();
    test_wide();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule